// File: doc/BRIEF.md
# Timer Control and Status Register

This block holds the 8-bit control and status byte of a multi-function timer. Software reaches it over a simple byte-wide register port: an address, a write strobe, write data, and read data decoded from the address. The timer core sends single-cycle event pulses into the block. A zero-detect pulse marks the counter reaching zero. A match pulse marks a compare-clear match. A trigger pulse marks a counter clear caused by the external trigger pin. The block sends back a one-cycle clear strobe for the counter and its prescaler, and it drives three registered interrupt requests.

Each interrupt request has a sticky flag and an enable bit. The top bit of the byte can only be written to zero, which starts a counter clear, and it always reads as one. A fan-out mode bit changes what a zero-detect pulse does: it raises all three flags together instead of the zero flag alone. This lets zero detection start service on three interrupt channels at once.

Bit map, MSB to LSB: bit 7 is the soft clear, bit 6 is fan-out mode, bit 5 is the trigger enable, bit 4 is the trigger flag, bit 3 is the zero enable, bit 2 is the zero flag, bit 1 is the match enable, and bit 0 is the match flag.

Top module: `tmr_ctl_status`

## Requirements
- R1: While reset is held, and just after it ends, the register reads 8'h80, all three interrupt requests are 0 and the clear strobe is 0.
- R2: Bit 7 of the read data is 1 whenever the register address is selected, whatever value was last written to it.
- R3: A write at the register address with bit 7 = 0 raises the clear strobe for exactly the one cycle after the write edge. A write with bit 7 = 1 raises no strobe.
- R4: Bits 6, 5, 3 and 1 (mode and the three enables) take the written value and read it back unchanged.
- R5: With mode bit 6 = 0, a zero-detect pulse sets only the zero flag (bit 2).
- R6: With mode bit 6 = 1, a zero-detect pulse sets bits 4, 2 and 0 on the same clock edge. The mode in effect is the one held before that edge.
- R7: A trigger pulse sets bit 4 and a match pulse sets bit 0, whatever the mode bit holds.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R9: When a hardware set and a software clear of the same flag land on the same edge, the flag ends up set.
- R10: Each interrupt request is a register equal to its flag AND its enable, and it changes on the same edge as the flag.
- R11: A write to any other address changes nothing and raises no strobe. The read data is 8'h00 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, decoded combinationally from the address |
| zeroEvt | input | 1 | Counter-reached-zero pulse |
| matchEvt | input | 1 | Compare-clear match pulse |
| trigEvt | input | 1 | External trigger clear pulse |
| cntClear | output | 1 | One-cycle clear for the counter and prescaler |
| irqTrig | output | 1 | Trigger-clear interrupt request |
| irqZero | output | 1 | Zero-detect interrupt request |
| irqMatch | output | 1 | Match interrupt request |

## Verification
Directed cases first drive a zero-detect pulse in each mode. Reading the flags back separates the single-flag behaviour from the three-flag fan-out, and a match pulse in fan-out mode shows that the match source is independent of the mode. A write that clears every flag on the same edge as a trigger pulse separates set-over-clear priority from clear-over-set. Writes of 0 and of 1 to bit 7, and a write to a foreign address, separate a real clear strobe from a spurious one. Seeded random traffic then mixes writes, events and foreign addresses against a bench model, which exposes wrong enable gating and wrong interrupt timing.

// File: rtl/tmr_ctl_status_pkg.sv
package tmr_ctl_status_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_SRC  = 3;        // 0 = match, 1 = zero, 2 = trigger
  localparam int SOFT_BIT = 7;
  localparam int MODE_BIT = 6;

  typedef struct packed {
    logic               wrHit;
    logic               swClear;
    logic               newMode;
    logic [NUM_SRC-1:0] clrFlag;
    logic [NUM_SRC-1:0] newIe;
  } ctlStrobes_t;
endpackage

// File: rtl/tmr_ctl_status_ctl.sv
module tmr_ctl_status_ctl
  import tmr_ctl_status_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output ctlStrobes_t       strb,
  output logic              cntClear
);
  logic hit;
  assign hit = busWrEn && (busAddr == REG_ADDR);

  always_comb begin
    strb         = '0;
    strb.wrHit   = hit;
    strb.swClear = hit && !busWrData[SOFT_BIT];
    strb.newMode = busWrData[MODE_BIT];
    for (int i = 0; i < NUM_SRC; i++) begin
      strb.clrFlag[i] = hit && !busWrData[2*i];
      strb.newIe[i]   = busWrData[2*i+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntClear <= 1'b0;
    else       cntClear <= strb.swClear;
  end

  // R3: strobe follows a zero write by one cycle, and only then
  assert_clear_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_ADDR && !busWrData[SOFT_BIT]) |=> cntClear);
  assert_no_spurious_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == REG_ADDR && !busWrData[SOFT_BIT]) |=> !cntClear);
endmodule

// File: rtl/tmr_ctl_status_dp.sv
module tmr_ctl_status_dp
  import tmr_ctl_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic               zeroEvt,
  input  logic               matchEvt,
  input  logic               trigEvt,
  output logic [REG_W-2:0]   regBits,
  output logic [NUM_SRC-1:0] irqVec
);
  logic               modeQ;
  logic [NUM_SRC-1:0] flagQ, enQ, setVec, flagNext, enNext;

  assign setVec = {trigEvt | (zeroEvt & modeQ), zeroEvt, matchEvt | (zeroEvt & modeQ)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeQ <= 1'b0;
    else if (strb.wrHit) modeQ <= strb.newMode;
  end
  assign regBits[MODE_BIT] = modeQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign flagNext[i] = setVec[i] | (flagQ[i] & ~strb.clrFlag[i]);
    assign enNext[i]   = strb.wrHit ? strb.newIe[i] : enQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i]  <= 1'b0;
        enQ[i]    <= 1'b0;
        irqVec[i] <= 1'b0;
      end else begin
        flagQ[i]  <= flagNext[i];
        enQ[i]    <= enNext[i];
        irqVec[i] <= flagNext[i] & enNext[i];
      end
    end

    assign regBits[2*i]   = flagQ[i];
    assign regBits[2*i+1] = enQ[i];

    // R10: a request is never raised without both its flag and enable
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
      irqVec[i] |-> (flagQ[i] && enQ[i]));
  end

  // R6: fan-out raises all three flags
  assert_zero_fanout_R6: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt && modeQ) |=> (flagQ == 3'b111));
  // R5: without fan-out, zero detect leaves the other flags alone
  assert_zero_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt && !modeQ && !matchEvt && !trigEvt && !flagQ[0] && !flagQ[2])
      |=> (flagQ[1] && !flagQ[0] && !flagQ[2]));
  // R9: set beats clear
  assert_trig_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigEvt |=> flagQ[2]);
  assert_match_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> flagQ[0]);
endmodule

// File: rtl/tmr_ctl_status.sv
module tmr_ctl_status
  import tmr_ctl_status_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              zeroEvt,
  input  logic              matchEvt,
  input  logic              trigEvt,
  output logic              cntClear,
  output logic              irqTrig,
  output logic              irqZero,
  output logic              irqMatch
);
  ctlStrobes_t        strb;
  logic [REG_W-2:0]   regBits;
  logic [NUM_SRC-1:0] irqVec;

  tmr_ctl_status_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strb(strb), .cntClear(cntClear));

  tmr_ctl_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .zeroEvt(zeroEvt),
    .matchEvt(matchEvt), .trigEvt(trigEvt), .regBits(regBits), .irqVec(irqVec));

  assign busRdData = (busAddr == REG_ADDR) ? {1'b1, regBits} : '0;
  assign irqMatch  = irqVec[0];
  assign irqZero   = irqVec[1];
  assign irqTrig   = irqVec[2];

  // R2: soft-clear bit reads as one
  assert_read_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR) |-> busRdData[SOFT_BIT]);
  // R11: foreign address reads zero
  assert_foreign_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> (busRdData == 8'h00));
endmodule

// File: tb/tmr_ctl_status_tb.sv
`timescale 1ns/1ps
module tmr_ctl_status_tb;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] RA = 6'h20;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = RA;
  logic busWrEn = 0, zeroEvt = 0, matchEvt = 0, trigEvt = 0;
  logic [7:0] busWrData = 8'h00, busRdData;
  logic cntClear, irqTrig, irqZero, irqMatch;

  int errors = 0, checks = 0;
  bit done = 0;
  logic mMode = 0, mCnt = 0;
  logic [2:0] mEn = 0, mFlag = 0;   // index 0 match, 1 zero, 2 trig

  always #10 clk = ~clk;

  tmr_ctl_status #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .zeroEvt(zeroEvt),
    .matchEvt(matchEvt), .trigEvt(trigEvt), .cntClear(cntClear),
    .irqTrig(irqTrig), .irqZero(irqZero), .irqMatch(irqMatch));

  function automatic logic [7:0] expRead();
    return {1'b1, mMode, mEn[2], mFlag[2], mEn[1], mFlag[1], mEn[0], mFlag[0]};
  endfunction

  function automatic logic [2:0] expIrq();
    return mFlag & mEn;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelEdge(input logic hit, input logic [7:0] d,
                           input logic z, input logic m, input logic t);
    logic [2:0] setV, clr;
    setV = {t | (z & mMode), z, m | (z & mMode)};
    clr  = hit ? ~{d[4], d[2], d[0]} : 3'b000;
    mFlag = setV | (mFlag & ~clr);
    if (hit) begin
      mEn   = {d[5], d[3], d[1]};
      mMode = d[6];
    end
    mCnt = hit & ~d[7];
  endtask

  task automatic step(input string req, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [7:0] d, input logic z, input logic m, input logic t);
    busWrEn = w; busAddr = a; busWrData = d;
    zeroEvt = z; matchEvt = m; trigEvt = t;
    @(posedge clk);
    modelEdge(w && (a == RA), d, z, m, t);
    @(negedge clk);
    busWrEn = 0; zeroEvt = 0; matchEvt = 0; trigEvt = 0; busAddr = RA;
    #1;
    chk(req, busRdData, expRead());
    chk("R3", {7'b0, cntClear}, {7'b0, mCnt});
    chk("R10", {5'b0, irqTrig, irqZero, irqMatch}, {5'b0, expIrq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1", busRdData, 8'h80);
    chk("R1", {5'b0, cntClear, irqTrig, irqZero}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", busRdData, 8'h80);
    chk("R1", {7'b0, irqMatch}, 8'h00);

    // R3: zero write pulses, one write does not
    step("R3", 1, RA, 8'h00, 0, 0, 0);
    chk("R3", {7'b0, cntClear}, 8'h01);
    step("R3", 0, RA, 8'h00, 0, 0, 0);
    chk("R3", {7'b0, cntClear}, 8'h00);
    step("R3", 1, RA, 8'h80, 0, 0, 0);
    chk("R3", {7'b0, cntClear}, 8'h00);
    // R4 and R2: write mode and enables, flags written as zero
    step("R4", 1, RA, 8'h6A, 0, 0, 0);
    chk("R4", busRdData, 8'hEA);
    chk("R2", busRdData & 8'h80, 8'h80);
    // R5: mode 0, zero detect sets only bit 2
    step("R5", 1, RA, 8'h80, 0, 0, 0);
    step("R5", 0, RA, 8'h00, 1, 0, 0);
    chk("R5", busRdData, 8'h84);
    // R6: mode 1 with flags cleared, zero detect sets bits 4,2,0
    step("R6", 1, RA, 8'hC0, 0, 0, 0);
    chk("R6", busRdData, 8'hC0);
    step("R6", 0, RA, 8'h00, 1, 0, 0);
    chk("R6", busRdData, 8'hD5);
    // R8: writing ones keeps flags; zero on bit 2 clears only it
    step("R8", 1, RA, 8'hD5, 0, 0, 0);
    chk("R8", busRdData, 8'hD5);
    step("R8", 1, RA, 8'hD1, 0, 0, 0);
    chk("R8", busRdData, 8'hD1);
    // R7: match in mode 1 sets only bit 0
    step("R7", 1, RA, 8'hC0, 0, 0, 0);
    step("R7", 0, RA, 8'h00, 0, 1, 0);
    chk("R7", busRdData, 8'hC1);
    // R9: clear all flags on the same edge as a trigger pulse, enable trig irq
    step("R9", 1, RA, 8'hA0, 0, 0, 1);
    chk("R9", busRdData, 8'hB0);
    chk("R10", {7'b0, irqTrig}, 8'h01);
    // R11: foreign write ignored, foreign read zero
    step("R11", 1, RA ^ 6'h01, 8'h00, 0, 0, 0);
    chk("R11", busRdData, 8'hB0);
    chk("R11", {7'b0, cntClear}, 8'h00);
    busAddr = RA ^ 6'h05; #1;
    chk("R11", busRdData, 8'h00);
    busAddr = RA;

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic w, z, m, t;
      logic [ADDR_W-1:0] a;
      w = ($urandom % 10) < 3;
      a = (($urandom % 4) == 0) ? ADDR_W'($urandom) : RA;
      z = ($urandom % 5) == 0;
      m = ($urandom % 6) == 0;
      t = ($urandom % 6) == 0;
      step("R8", w, a, 8'($urandom), z, m, t);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule